// File: doc/BRIEF.md
# Transmit Completion Status Queue

This block keeps a short record of every transmission the transmit engine finishes. Each record is one status byte. It holds a done marker, the per-frame interrupt-request flag and the error flags that were reported with the completion. Records wait in a small first-in first-out queue. The host sees the oldest record on a byte-wide read port. A host write strobe to that port discards the oldest record and brings the next one forward.

The block also derives three side signals from the same completions:
- a one-cycle event pulse, raised when a completion needs host attention;
- a one-cycle adapter-failure pulse, raised when the transmit FIFO overruns;
- a sticky transmitter-disable flag, set by fatal errors.

A transmit reset empties the queue and lifts the disable flag. When the queue is full, a new completion is not stored. Its loss is shown by a marker bit in the newest record still held.

Top module: `txstat_stack`

## Requirements
- R1: A stored record has bit 7 = 1 (done), bit 6 = interrupt request, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow marker, and bits 1:0 = 0.
- R2: While the queue is empty, `rd_byte` reads 8'h00, so bit 7 is clear.
- R3: Records are read out in completion order. A `host_wr` pulse removes the oldest record. A `host_wr` pulse on an empty queue has no effect.
- R4: With DEPTH records held and no pop in the same cycle, a completion is dropped and bit 2 is set in the newest held record. A pop and a completion in the same cycle on a full queue store the completion.
- R5: `txc_event` pulses for one cycle, one cycle after a completion whose interrupt-request bit or any error bit is set. A completion with none of these raises no event.
- R6: A completion carrying jabber or underrun sets `tx_disable` on the next cycle. The flag stays set until a transmit reset.
- R7: `tx_overrun` produces a one-cycle `adp_fail` pulse on the next cycle and sets `tx_disable`.
- R8: `tx_reset` empties the queue and clears `tx_disable` on the next cycle. A completion or pop in the same cycle is discarded and raises no event.
- R9: After the asynchronous reset, `rd_byte`, `txc_event`, `adp_fail` and `tx_disable` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Completion strobe from the transmit engine |
| cmp_intreq | input | 1 | Frame requested an interrupt on success |
| cmp_jabber | input | 1 | Jabber error on this frame |
| cmp_underrun | input | 1 | Underrun on this frame |
| cmp_maxcoll | input | 1 | Maximum collisions reached |
| tx_overrun | input | 1 | Transmit FIFO overrun strobe |
| tx_reset | input | 1 | Transmit reset command |
| host_wr | input | 1 | Host write to the status port (pop) |
| rd_byte | output | 8 | Oldest record, or 0 when empty |
| txc_event | output | 1 | TX-complete event pulse |
| adp_fail | output | 1 | Adapter-failure event pulse |
| tx_disable | output | 1 | Transmitter forced off |

## Verification
The hardest situation to reach is a full queue meeting further completions. Two cases must be shown there: the overflow marker landing on the newest record rather than the oldest, and a pop arriving in the same cycle as a completion. The stimulus fills the queue with distinct flag patterns and then issues completions with the host idle. It then issues a completion together with a pop, and drains the queue to expose each byte in order. A random phase then mixes pops, completions, overruns and resets at a high rate, so that the queue often sits at its bounds.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  typedef logic [7:0] stat_t;

  localparam int unsigned BIT_DONE = 7;
  localparam int unsigned BIT_IRQ  = 6;
  localparam int unsigned BIT_JAB  = 5;
  localparam int unsigned BIT_UND  = 4;
  localparam int unsigned BIT_MAXC = 3;
  localparam int unsigned BIT_OVF  = 2;

  typedef struct packed {
    logic irq;
    logic jab;
    logic und;
    logic maxc;
  } cmp_flags_t;

  function automatic stat_t build_rec(cmp_flags_t f);
    stat_t r;
    r = '0;
    r[BIT_DONE] = 1'b1;
    r[BIT_IRQ]  = f.irq;
    r[BIT_JAB]  = f.jab;
    r[BIT_UND]  = f.und;
    r[BIT_MAXC] = f.maxc;
    return r;
  endfunction
endpackage

// File: rtl/txstat_fifo.sv
module txstat_fifo
  import txstat_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic                         pop,
  input  stat_t                        din,
  output stat_t                        dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d, newest;
  logic [CW-1:0] cnt_q, cnt_d;
  stat_t         mem_q [DEPTH];
  logic          pop_ok, room, push_ok, ovf;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop_ok  = pop && (cnt_q != '0);
    room    = (cnt_q != FULLC) || pop_ok;
    push_ok = push && room;
    ovf     = push && !room;
    newest  = (wr_q == '0) ? LAST : wr_q - 1'b1;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = nxt(wr_q);
      if (pop_ok)  rd_d = nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic  we;
    stat_t wdat;
    always_comb begin
      we   = !flush && ((push_ok && (wr_q == PW'(i))) || (ovf && (newest == PW'(i))));
      wdat = push_ok ? din : (mem_q[i] | stat_t'(1 << BIT_OVF));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[i] <= '0;
      else if (we) mem_q[i] <= wdat;
    end
  end

  assign dout  = (cnt_q == '0) ? '0 : mem_q[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/txstat_ctrl.sv
module txstat_ctrl
  import txstat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_valid,
  input  cmp_flags_t flags,
  input  logic       tx_overrun,
  input  logic       tx_reset,
  input  logic       host_wr,
  output logic       push,
  output logic       pop,
  output stat_t      rec,
  output logic       txc_event,
  output logic       adp_fail,
  output logic       tx_disable
);
  logic evt_q, evt_d, fail_q, fail_d, dis_q, dis_d;
  logic fatal;

  always_comb begin
    push   = cmp_valid && !tx_reset;
    pop    = host_wr && !tx_reset;
    rec    = build_rec(flags);
    fatal  = push && (flags.jab || flags.und);
    evt_d  = push && (flags.irq || flags.jab || flags.und || flags.maxc);
    fail_d = tx_overrun;
    if (tx_reset) dis_d = 1'b0;
    else          dis_d = dis_q || fatal || tx_overrun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      fail_q <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      evt_q  <= evt_d;
      fail_q <= fail_d;
      dis_q  <= dis_d;
    end
  end

  assign txc_event  = evt_q;
  assign adp_fail   = fail_q;
  assign tx_disable = dis_q;
endmodule

// File: rtl/txstat_stack.sv
module txstat_stack
  import txstat_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_valid,
  input  logic       cmp_intreq,
  input  logic       cmp_jabber,
  input  logic       cmp_underrun,
  input  logic       cmp_maxcoll,
  input  logic       tx_overrun,
  input  logic       tx_reset,
  input  logic       host_wr,
  output logic [7:0] rd_byte,
  output logic       txc_event,
  output logic       adp_fail,
  output logic       tx_disable
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  cmp_flags_t      flags;
  logic            push, pop;
  stat_t           rec, dout;
  logic [CW-1:0]   fill_cnt;

  assign flags = '{irq: cmp_intreq, jab: cmp_jabber, und: cmp_underrun, maxc: cmp_maxcoll};

  txstat_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_valid  (cmp_valid),
    .flags      (flags),
    .tx_overrun (tx_overrun),
    .tx_reset   (tx_reset),
    .host_wr    (host_wr),
    .push       (push),
    .pop        (pop),
    .rec        (rec),
    .txc_event  (txc_event),
    .adp_fail   (adp_fail),
    .tx_disable (tx_disable)
  );

  txstat_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_reset),
    .push  (push),
    .pop   (pop),
    .din   (rec),
    .dout  (dout),
    .count (fill_cnt)
  );

  assign rd_byte = dout;
endmodule

// File: rtl/txstat_chk.sv
module txstat_chk #(
  parameter int unsigned DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmp_valid,
  input logic                       cmp_intreq,
  input logic                       cmp_jabber,
  input logic                       cmp_underrun,
  input logic                       cmp_maxcoll,
  input logic                       tx_overrun,
  input logic                       tx_reset,
  input logic [7:0]                 rd_byte,
  input logic                       txc_event,
  input logic                       adp_fail,
  input logic                       tx_disable,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_byte[1:0] == 2'b00); // R1
  AST_DONE_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n) (fill != 0) |-> rd_byte[7]); // R1
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (fill == 0) |-> (rd_byte == 8'h00)); // R2
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) fill <= ($clog2(DEPTH+1))'(DEPTH)); // R4
  AST_EVENT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (cmp_valid && !tx_reset && (cmp_intreq || cmp_jabber || cmp_underrun || cmp_maxcoll)) |=> txc_event); // R5
  AST_CLEAN_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n) !(cmp_valid && !tx_reset && (cmp_intreq || cmp_jabber || cmp_underrun || cmp_maxcoll)) |=> !txc_event); // R5
  AST_DISABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (tx_disable && !tx_reset) |=> tx_disable); // R6
  AST_FATAL_DISABLES: assert property (@(posedge clk) disable iff (!rst_n) (cmp_valid && !tx_reset && (cmp_jabber || cmp_underrun)) |=> tx_disable); // R6
  AST_OVERRUN_FAILS: assert property (@(posedge clk) disable iff (!rst_n) tx_overrun |=> adp_fail); // R7
  AST_OVERRUN_DISABLES: assert property (@(posedge clk) disable iff (!rst_n) (tx_overrun && !tx_reset) |=> tx_disable); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) tx_reset |=> (!tx_disable && fill == 0 && !txc_event)); // R8
endmodule

bind txstat_stack txstat_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmp_valid    (cmp_valid),
  .cmp_intreq   (cmp_intreq),
  .cmp_jabber   (cmp_jabber),
  .cmp_underrun (cmp_underrun),
  .cmp_maxcoll  (cmp_maxcoll),
  .tx_overrun   (tx_overrun),
  .tx_reset     (tx_reset),
  .rd_byte      (rd_byte),
  .txc_event    (txc_event),
  .adp_fail     (adp_fail),
  .tx_disable   (tx_disable),
  .fill         (fill_cnt)
);

// File: tb/sim_txstat_stack.sv
`timescale 1ns/1ps
module sim_txstat_stack;
  localparam int DEPTH = 4;

  logic clk, rst_n;
  logic cmp_valid, cmp_intreq, cmp_jabber, cmp_underrun, cmp_maxcoll;
  logic tx_overrun, tx_reset, host_wr;
  logic [7:0] rd_byte;
  logic txc_event, adp_fail, tx_disable;

  int total = 0;
  int bad = 0;
  string ph = "R9";

  txstat_stack #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_intreq(cmp_intreq),
    .cmp_jabber(cmp_jabber), .cmp_underrun(cmp_underrun), .cmp_maxcoll(cmp_maxcoll),
    .tx_overrun(tx_overrun), .tx_reset(tx_reset), .host_wr(host_wr),
    .rd_byte(rd_byte), .txc_event(txc_event), .adp_fail(adp_fail), .tx_disable(tx_disable)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [7:0] mq[$];
  logic m_evt, m_fail, m_dis;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_evt = 1'b0; m_fail = 1'b0; m_dis = 1'b0;
    end else begin
      m_evt  = cmp_valid && !tx_reset && (cmp_intreq || cmp_jabber || cmp_underrun || cmp_maxcoll);
      m_fail = tx_overrun;
      if (tx_reset) begin
        mq.delete();
        m_dis = 1'b0;
      end else begin
        if (host_wr && mq.size() > 0) void'(mq.pop_front());
        if (cmp_valid) begin
          if (mq.size() < DEPTH)
            mq.push_back({1'b1, cmp_intreq, cmp_jabber, cmp_underrun, cmp_maxcoll, 3'b000});
          else
            mq[mq.size()-1] = mq[mq.size()-1] | 8'h04;
        end
        if ((cmp_valid && (cmp_jabber || cmp_underrun)) || tx_overrun) m_dis = 1'b1;
      end
    end
  end

  task automatic cmp1(string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h t=%0t", ph, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    cmp1("rd_byte", rd_byte, (mq.size() > 0) ? mq[0] : 8'h00);
    cmp1("txc_event", {7'b0, txc_event}, {7'b0, m_evt});
    cmp1("adp_fail", {7'b0, adp_fail}, {7'b0, m_fail});
    cmp1("tx_disable", {7'b0, tx_disable}, {7'b0, m_dis});
  endtask

  task automatic idle_inputs();
    cmp_valid = 0; cmp_intreq = 0; cmp_jabber = 0; cmp_underrun = 0; cmp_maxcoll = 0;
    tx_overrun = 0; tx_reset = 0; host_wr = 0;
  endtask

  // one clock: inputs already set, then sample at the next falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_all();
    idle_inputs();
  endtask

  task automatic comp(logic irq, logic jab, logic und, logic mc, logic pop);
    cmp_valid = 1; cmp_intreq = irq; cmp_jabber = jab; cmp_underrun = und; cmp_maxcoll = mc;
    host_wr = pop;
    tick();
  endtask

  task automatic pop1();
    host_wr = 1;
    tick();
  endtask

  task automatic xreset();
    tx_reset = 1;
    tick();
  endtask

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    ph = "R9";
    check_all();              // R9 reset state
    rst_n = 1;
    tick();

    ph = "R1";                // R1 R5 field layout, clean frame with no event
    comp(0, 0, 0, 0, 0);
    comp(1, 0, 0, 0, 0);
    comp(0, 0, 0, 1, 0);
    ph = "R3";                // R3 order and pops
    pop1(); pop1(); pop1();
    ph = "R2";                // R2 empty reads zero, pop on empty ignored (R3)
    pop1(); pop1();
    comp(1, 0, 0, 1, 0);
    pop1();

    ph = "R4";                // R4 fill then overflow
    comp(1, 0, 0, 0, 0);
    comp(0, 0, 0, 1, 0);
    comp(1, 0, 0, 1, 0);
    comp(0, 0, 0, 0, 0);
    comp(0, 0, 0, 0, 0);      // dropped, marks newest
    comp(1, 0, 0, 0, 0);      // dropped again
    comp(0, 0, 0, 1, 1);      // pop with completion on full: stored
    repeat (5) pop1();

    ph = "R6";                // R6 jabber then underrun, sticky
    comp(0, 1, 0, 0, 0);
    repeat (3) tick();
    ph = "R8";                // R8 transmit reset with completion same cycle
    cmp_valid = 1; cmp_intreq = 1; host_wr = 1;
    xreset();
    tick();
    ph = "R6";
    comp(0, 0, 1, 0, 0);
    tick();
    ph = "R8";
    xreset();

    ph = "R7";                // R7 overrun
    tx_overrun = 1;
    tick();
    tick();
    ph = "R8";
    xreset();

    ph = "RND";               // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      automatic int r = $urandom_range(0, 99);
      cmp_valid    = (r < 55);
      cmp_intreq   = $urandom_range(0, 1);
      cmp_jabber   = ($urandom_range(0, 15) == 0);
      cmp_underrun = ($urandom_range(0, 15) == 0);
      cmp_maxcoll  = ($urandom_range(0, 3) == 0);
      host_wr      = ($urandom_range(0, 99) < 40);
      tx_overrun   = ($urandom_range(0, 99) < 2);
      tx_reset     = ($urandom_range(0, 99) < 3);
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule